// File: doc/BRIEF.md
# Reset Status and Power Control Register

This block is the 8-bit system status and control register of a small microcontroller core. It answers at one fixed address on a simple register bus, with writes taking effect at a clock edge and reads returned combinationally. It reports what caused the most recent reset: a power-on or external reset, or a watchdog reset. It also reflects the global interrupt enable flag so that software can read it.

Software can use the register to put the core to sleep. The sleep state ends by itself as soon as any interrupt is pending. Software can also halt the core with a stop bit, and only a hardware reset releases that bit. The block drives three outputs: a sleep request, a halt request and a watchdog-enable indication. The watchdog is armed once software clears the power-on flag.

The asynchronous active-low power-on/external reset is released through a synchronizer. A watchdog reset arrives as a synchronous one-cycle pulse.

Top module: `sys_status_ctrl`

## Requirements
- R1: After a power-on/external reset, a read of address FFh returns 0x10 while the interrupt-enable input is 0, and sleep_req_o, halt_req_o and wdt_enable_o are all 0.
- R2: Only address FFh is decoded. A read at any other address returns 0x00, and a write to any other address changes no bit and no output.
- R3: Read bit 7 equals the gie_i input. Writing bit 7 has no effect.
- R4: Bit 5 (watchdog-reset flag) is set only by a watchdog reset. Writing 0 to it clears it at the next edge, and writing 1 leaves it unchanged.
- R5: Bit 4 (power-on flag) is set only by a power-on/external reset. Writing 0 clears it, and writing 1 leaves it unchanged. wdt_enable_o is 1 exactly while bit 4 is 0.
- R6: Bit 3 (sleep) is read/write. sleep_req_o is 1 while bit 3 is 1 and irq_pending_i is 0.
- R7: While irq_pending_i is 1, sleep_req_o is 0 in that same cycle and bit 3 is 0 after the next edge. A write of 1 to bit 3 while an interrupt is pending leaves it 0.
- R8: Bit 0 (stop) is set by writing 1 and drives halt_req_o. Writing 0 does not clear it. Only a power-on/external or watchdog reset clears it.
- R9: A watchdog reset pulse sets bit 5, clears bits 3 and 0, and keeps bit 4. It takes precedence over a register write in the same cycle.
- R10: Reserved bits 6, 2 and 1 always read 0, whatever was written to them.
- R11: Reads never change any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on/external reset, active low, asynchronous assertion |
| wdt_rst_i | input | 1 | Watchdog reset event, one-cycle synchronous pulse |
| reg_addr | input | 8 | Register bus address |
| reg_wr_en | input | 1 | Register bus write strobe |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data, combinational |
| gie_i | input | 1 | Global interrupt enable flag from the core |
| irq_pending_i | input | 1 | Any interrupt pending |
| sleep_req_o | output | 1 | Sleep request to the core |
| halt_req_o | output | 1 | Halt request to the core |
| wdt_enable_o | output | 1 | Watchdog enable |

## Verification
The hardest situations to reach are the collisions: a watchdog reset landing in the same cycle as a software write, and a sleep write landing while an interrupt is already pending. In both, the priority decides the result. The bench aligns the watchdog pulse and the write strobe on the same clock edge. It holds irq_pending_i high across a sleep write. The power-on flag's survival through a watchdog reset only shows when that flag is still 1, so the bench first applies a fresh hardware reset, then sets stop and fires the watchdog.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned BIT_GIE  = 7;
  localparam int unsigned BIT_WDR  = 5;
  localparam int unsigned BIT_POR  = 4;
  localparam int unsigned BIT_SLP  = 3;
  localparam int unsigned BIT_STOP = 0;

  typedef struct packed {
    logic wdr;
    logic por;
    logic sleep;
    logic stop;
  } scr_state_t;
endpackage

// File: rtl/scr_rst_sync.sv
module scr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/scr_bus_dec.sv
module scr_bus_dec #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              hit,
  output logic              wr_stb
);
  assign hit    = (addr == REG_ADDR);
  assign wr_stb = wr_en & hit;
endmodule

// File: rtl/scr_flags.sv
module scr_flags
  import scr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       wd_wdr,
  input  logic       wd_por,
  input  logic       wd_sleep,
  input  logic       wd_stop,
  input  logic       wdt_rst,
  input  logic       irq_pending,
  output scr_state_t state
);
  scr_state_t st_q, st_d;
  logic       st_en;

  always_comb begin
    st_d  = st_q;
    st_en = wr_stb | wdt_rst | (st_q.sleep & irq_pending);
    if (wdt_rst) begin
      st_d.wdr   = 1'b1;
      st_d.sleep = 1'b0;
      st_d.stop  = 1'b0;
    end else begin
      if (wr_stb) begin
        st_d.wdr   = st_q.wdr & wd_wdr;
        st_d.por   = st_q.por & wd_por;
        st_d.sleep = wd_sleep;
        st_d.stop  = st_q.stop | wd_stop;
      end
      if (irq_pending) st_d.sleep = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.wdr   <= 1'b0;
      st_q.por   <= 1'b1;
      st_q.sleep <= 1'b0;
      st_q.stop  <= 1'b0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/sys_status_ctrl.sv
module sys_status_ctrl
  import scr_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'hFF,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              gie_i,
  input  logic              irq_pending_i,
  output logic              sleep_req_o,
  output logic              halt_req_o,
  output logic              wdt_enable_o
);
  logic       rst_sync_n;
  logic       hit, wr_stb;
  scr_state_t st;
  logic       unused_wdata_bits;

  scr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  scr_bus_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .addr(reg_addr), .wr_en(reg_wr_en), .hit(hit), .wr_stb(wr_stb)
  );

  scr_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb),
    .wd_wdr(reg_wdata[BIT_WDR]), .wd_por(reg_wdata[BIT_POR]),
    .wd_sleep(reg_wdata[BIT_SLP]), .wd_stop(reg_wdata[BIT_STOP]),
    .wdt_rst(wdt_rst_i), .irq_pending(irq_pending_i), .state(st)
  );

  assign unused_wdata_bits = ^{reg_wdata[7:6], reg_wdata[2:1]};

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      reg_rdata[BIT_GIE]  = gie_i;
      reg_rdata[BIT_WDR]  = st.wdr;
      reg_rdata[BIT_POR]  = st.por;
      reg_rdata[BIT_SLP]  = st.sleep;
      reg_rdata[BIT_STOP] = st.stop;
    end
  end

  assign sleep_req_o  = st.sleep & ~irq_pending_i;
  assign halt_req_o   = st.stop;
  assign wdt_enable_o = ~st.por;
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFF
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wdt_rst_i,
  input logic              irq_pending_i,
  input logic              gie_i,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              sleep_req_o,
  input logic              halt_req_o,
  input logic              wdr_q,
  input logic              por_q,
  input logic              sleep_q
);
  a_r2_other_addr_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr != REG_ADDR) |-> (reg_rdata == 8'h00));
  a_r3_gie_mirror: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr == REG_ADDR) |-> (reg_rdata[7] == gie_i));
  a_r4_wdr_only_by_wdt: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(wdr_q) |-> $past(wdt_rst_i));
  a_r5_por_never_rises: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$rose(por_q));
  a_r6_sleep_req_quiet_on_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sleep_req_o |-> !irq_pending_i);
  a_r7_irq_ends_sleep: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_pending_i |=> !sleep_q);
  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt_req_o && !wdt_rst_i) |=> halt_req_o);
  a_r9_wdt_effect: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wdt_rst_i |=> (wdr_q && !halt_req_o && !sleep_q && (por_q == $past(por_q))));
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rdata[6] == 1'b0) && (reg_rdata[2:1] == 2'b00));
endmodule

bind sys_status_ctrl scr_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wdt_rst_i(wdt_rst_i),
  .irq_pending_i(irq_pending_i), .gie_i(gie_i), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .sleep_req_o(sleep_req_o), .halt_req_o(halt_req_o),
  .wdr_q(st.wdr), .por_q(st.por), .sleep_q(st.sleep)
);

// File: tb/sim_sys_status_ctrl.sv
`timescale 1ns/1ps
module sim_sys_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, wdt_rst_i, reg_wr_en, gie_i, irq_pending_i;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sleep_req_o, halt_req_o, wdt_enable_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sys_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt_rst_i), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gie_i(gie_i), .irq_pending_i(irq_pending_i), .sleep_req_o(sleep_req_o),
    .halt_req_o(halt_req_o), .wdt_enable_o(wdt_enable_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wdt_pulse();
    @(negedge clk);
    wdt_rst_i = 1'b1;
    @(negedge clk);
    wdt_rst_i = 1'b0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    hw_reset();
    rd(8'hFF, d);
    chk("R1 reset value", d, 8'h10);
    chk("R1 reset outputs", {5'b0, sleep_req_o, halt_req_o, wdt_enable_o}, 8'h00);
  endtask

  task automatic t_por();
    logic [7:0] d;
    wr(8'hFF, 8'h10);
    rd(8'hFF, d);
    chk("R5 write 1 keeps por", d, 8'h10);
    chk("R5 wdt disabled", {7'b0, wdt_enable_o}, 8'h00);
    wr(8'hFF, 8'h00);
    rd(8'hFF, d);
    chk("R5 write 0 clears por", d, 8'h00);
    chk("R5 wdt enabled", {7'b0, wdt_enable_o}, 8'h01);
  endtask

  task automatic t_wdr();
    logic [7:0] d;
    wdt_pulse();
    rd(8'hFF, d);
    chk("R4 wdt sets flag", d, 8'h20);
    wr(8'hFF, 8'h30);
    rd(8'hFF, d);
    chk("R4 write 1 keeps, no por set", d, 8'h20);
    wr(8'hFF, 8'h00);
    rd(8'hFF, d);
    chk("R4 write 0 clears", d, 8'h00);
  endtask

  task automatic t_gie();
    logic [7:0] d;
    gie_i = 1'b1;
    rd(8'hFF, d);
    chk("R3 gie mirror", d, 8'h80);
    gie_i = 1'b0;
    wr(8'hFF, 8'h80);
    rd(8'hFF, d);
    chk("R3 bit7 write ignored", d, 8'h00);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    wr(8'h7F, 8'h09);
    rd(8'hFF, d);
    chk("R2 foreign write ignored", d, 8'h00);
    chk("R2 outputs unchanged", {6'b0, sleep_req_o, halt_req_o}, 8'h00);
    rd(8'hFE, d);
    chk("R2 foreign read zero", d, 8'h00);
  endtask

  task automatic t_sleep();
    logic [7:0] d;
    wr(8'hFF, 8'h08);
    rd(8'hFF, d);
    chk("R6 sleep set", d, 8'h08);
    chk("R6 sleep_req", {7'b0, sleep_req_o}, 8'h01);
    @(negedge clk);
    irq_pending_i = 1'b1;
    #1 chk("R7 sleep_req drops same cycle", {7'b0, sleep_req_o}, 8'h00);
    rd(8'hFF, d);
    chk("R7 sleep bit cleared", d, 8'h00);
    wr(8'hFF, 8'h08);
    rd(8'hFF, d);
    chk("R7 set while pending ignored", d, 8'h00);
    irq_pending_i = 1'b0;
    #1 chk("R7 no sleep after irq", {7'b0, sleep_req_o}, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    wr(8'hFF, 8'h01);
    rd(8'hFF, d);
    chk("R8 stop set", d, 8'h01);
    chk("R8 halt_req", {7'b0, halt_req_o}, 8'h01);
    wr(8'hFF, 8'h00);
    rd(8'hFF, d);
    chk("R8 write 0 keeps stop", d, 8'h01);
    hw_reset();
    rd(8'hFF, d);
    chk("R8 hw reset clears stop", d, 8'h10);
  endtask

  task automatic t_wdt_reset();
    logic [7:0] d;
    wr(8'hFF, 8'h19);
    rd(8'hFF, d);
    chk("R9 precondition", d, 8'h19);
    wdt_pulse();
    rd(8'hFF, d);
    chk("R9 wdt keeps por, clears sleep/stop", d, 8'h30);
    chk("R9 halt released", {7'b0, halt_req_o}, 8'h00);
    wr(8'hFF, 8'h00);
    wr(8'hFF, 8'h01);
    @(negedge clk);
    reg_addr = 8'hFF; reg_wdata = 8'h08; reg_wr_en = 1'b1; wdt_rst_i = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; wdt_rst_i = 1'b0;
    rd(8'hFF, d);
    chk("R9 wdt beats same-cycle write", d, 8'h20);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(8'hFF, 8'h66);
    rd(8'hFF, d);
    chk("R10 reserved read zero", d & 8'h46, 8'h00);
  endtask

  task automatic t_read_only();
    logic [7:0] d1, d2;
    rd(8'hFF, d1);
    rd(8'hFF, d2);
    chk("R11 read stable", d2, d1);
    chk("R11 wdr kept after reads", d2 & 8'h20, 8'h20);
  endtask

  initial begin
    rst_n = 1'b0; wdt_rst_i = 1'b0; reg_wr_en = 1'b0; gie_i = 1'b0;
    irq_pending_i = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    t_reset();
    t_por();
    t_wdr();
    t_gie();
    t_decode();
    t_sleep();
    t_stop();
    t_wdt_reset();
    t_reserved();
    t_read_only();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule